// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of translation tables from memory. A request carries the virtual address and two access qualifiers: whether it is a write and whether it comes from user mode. The walker does the lookups and then returns one of three results. The first is a physical address with its page attributes. The second is a not-present fault. The third is a protection fault. It does not cache translations. It does not service faults.

The address is split 10/10/12. The top ten bits index a 1024-entry directory. The directory's base comes from a root register. The next ten bits index a 1024-entry page table. That table's base comes from the directory entry. Each table of 32-bit entries fills exactly one 4 KiB page. The low twelve bits are the page offset and pass through unchanged.

A fault aborts the access and returns the virtual address that faulted, so the access can be restarted after the page is brought in. The root register is written through a separate control strobe. That strobe is honoured only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: The first read goes to address `{root[31:12], va[31:22], 2'b00}`. The second read goes to address `{dir[31:12], va[21:12], 2'b00}`, where `dir` is the word returned by the first read. Each read is a one-cycle `mem_req` pulse.
- R3: When both entries are present and the access is permitted, the walk makes exactly two reads and ends with a response where `rsp_paddr = {pte[31:12], va[11:0]}` and both fault flags are 0.
- R4: Entry encoding: bit 0 is present, bit 1 is writable, bit 2 is user-accessible, bit 3 is cache-disable and bit 4 is locked. `rsp_nocache` and `rsp_locked` copy bits 3 and 4 of the page entry. `rsp_writable` is the AND of bit 1 in both entries. `rsp_user` is the AND of bit 2 in both entries.
- R5: If the directory entry has bit 0 clear, the walk ends with `rsp_fault_np` set after exactly one read. If the page entry has bit 0 clear, the walk ends with `rsp_fault_np` set after two reads.
- R6: If both entries are present and either condition below holds, the walk ends with `rsp_fault_prot` set and `rsp_fault_np` clear:
  - a write is made where the combined writable bit is 0;
  - a user access is made where the combined user bit is 0.
- R7: Every response, fault or not, shows the request's virtual address on `rsp_vaddr`.
- R8: A `root_we` strobe updates the root only while `req_ready` is 1. If it arrives during a walk it is dropped. A root written in the same cycle a request is accepted applies from the next walk.
- R9: `rsp_valid` is high for exactly one cycle, and `req_ready` is 1 in the next cycle. While a walk is in progress `req_ready` is 0 and requests are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Root register write strobe |
| root_wdata | input | 32 | New root; bits 31:12 are kept |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| req_ready | output | 1 | Walker idle, request will be taken |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_paddr | output | 32 | Physical address |
| rsp_vaddr | output | 32 | Virtual address of the finished walk |
| rsp_fault_np | output | 1 | Not-present fault |
| rsp_fault_prot | output | 1 | Protection fault |
| rsp_writable | output | 1 | Combined writable attribute |
| rsp_user | output | 1 | Combined user attribute |
| rsp_nocache | output | 1 | Cache-disable attribute |
| rsp_locked | output | 1 | Page is locked (non-swappable) |

## Verification
The hardest case to reach from the ports is a root write that lands while a walk is waiting on memory. The write must be dropped silently, and the only evidence is the address used by a later walk.

The bench covers this directly. It strobes `root_we` with a different value during the fetch wait, which is stretched by the randomised memory latency. It then walks an address whose tables exist only under the old root, and checks both the read addresses and the result.

Mixed-level cases are built explicitly: a writable page under a read-only directory, and a user page under a supervisor directory. These exercise the ANDing of attributes across the two levels. Random tables cover the rest.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        root_we,
  input  logic [31:0] root_wdata,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_user,
  output logic        req_ready,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic [31:0] rsp_vaddr,
  output logic        rsp_fault_np,
  output logic        rsp_fault_prot,
  output logic        rsp_writable,
  output logic        rsp_user,
  output logic        rsp_nocache,
  output logic        rsp_locked
);
  localparam int OFS_W = 12;
  localparam int IDX_W = 10;
  localparam int FRM_W = 32 - OFS_W;
  localparam int B_P = 0, B_W = 1, B_U = 2, B_CD = 3, B_LK = 4;

  typedef enum logic [2:0] {IDLE, FETCH_DIR, FETCH_PTE, DONE, FAULT} st_t;

  st_t              st;
  logic [FRM_W-1:0] root_q;
  logic [31:0]      va_q, addr_q, pa_q;
  logic             wr_q, usr_q, issued, dir_w, dir_u;
  logic             f_np, f_prot, a_w, a_u, a_cd, a_lk;

  wire unused_bits = ^{mem_rdata[11:5], root_wdata[OFS_W-1:0]};

  wire pte_w  = dir_w & mem_rdata[B_W];
  wire pte_u  = dir_u & mem_rdata[B_U];
  wire denied = (wr_q & ~pte_w) | (usr_q & ~pte_u);
  wire got    = issued & mem_rvalid;

  assign req_ready      = (st == IDLE);
  assign mem_req        = (st == FETCH_DIR || st == FETCH_PTE) && !issued;
  assign mem_addr       = addr_q;
  assign rsp_valid      = (st == DONE) || (st == FAULT);
  assign rsp_paddr      = pa_q;
  assign rsp_vaddr      = va_q;
  assign rsp_fault_np   = f_np;
  assign rsp_fault_prot = f_prot;
  assign rsp_writable   = a_w;
  assign rsp_user       = a_u;
  assign rsp_nocache    = a_cd;
  assign rsp_locked     = a_lk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      root_q <= '0;
      va_q <= '0;
      addr_q <= '0;
      pa_q <= '0;
      wr_q <= 1'b0;
      usr_q <= 1'b0;
      issued <= 1'b0;
      dir_w <= 1'b0;
      dir_u <= 1'b0;
      f_np <= 1'b0;
      f_prot <= 1'b0;
      a_w <= 1'b0;
      a_u <= 1'b0;
      a_cd <= 1'b0;
      a_lk <= 1'b0;
    end else begin
      case (st)
        IDLE: begin
          if (root_we) root_q <= root_wdata[31:OFS_W];
          if (req_valid) begin
            va_q   <= req_vaddr;
            wr_q   <= req_write;
            usr_q  <= req_user;
            addr_q <= {root_q, req_vaddr[31 -: IDX_W], 2'b00};
            issued <= 1'b0;
            st     <= FETCH_DIR;
          end
        end
        FETCH_DIR: begin
          issued <= 1'b1;
          if (got) begin
            if (!mem_rdata[B_P]) begin
              f_np   <= 1'b1;
              f_prot <= 1'b0;
              st     <= FAULT;
            end else begin
              dir_w  <= mem_rdata[B_W];
              dir_u  <= mem_rdata[B_U];
              addr_q <= {mem_rdata[31:OFS_W], va_q[OFS_W +: IDX_W], 2'b00};
              issued <= 1'b0;
              st     <= FETCH_PTE;
            end
          end
        end
        FETCH_PTE: begin
          issued <= 1'b1;
          if (got) begin
            pa_q <= {mem_rdata[31:OFS_W], va_q[OFS_W-1:0]};
            a_w  <= pte_w;
            a_u  <= pte_u;
            a_cd <= mem_rdata[B_CD];
            a_lk <= mem_rdata[B_LK];
            if (!mem_rdata[B_P]) begin
              f_np   <= 1'b1;
              f_prot <= 1'b0;
              st     <= FAULT;
            end else if (denied) begin
              f_np   <= 1'b0;
              f_prot <= 1'b1;
              st     <= FAULT;
            end else begin
              f_np   <= 1'b0;
              f_prot <= 1'b0;
              st     <= DONE;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req,
  input logic        rsp_valid,
  input logic        rsp_fault_np,
  input logic        rsp_fault_prot,
  input logic [11:0] pa_ofs,
  input logic [11:0] va_ofs
);
  assert_busy_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  assert_read_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  assert_one_fault_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_fault_np && rsp_fault_prot));
  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault_np && !rsp_fault_prot) |-> (pa_ofs == va_ofs));
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req(mem_req),
  .rsp_valid(rsp_valid), .rsp_fault_np(rsp_fault_np), .rsp_fault_prot(rsp_fault_prot),
  .pa_ofs(rsp_paddr[11:0]), .va_ofs(rsp_vaddr[11:0])
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic clk = 0, rst_n = 0;
  logic root_we = 0, req_valid = 0, req_write = 0, req_user = 0;
  logic [31:0] root_wdata = 0, req_vaddr = 0;
  logic req_ready, mem_req, mem_rvalid, rsp_valid;
  logic [31:0] mem_addr, mem_rdata, rsp_paddr, rsp_vaddr;
  logic rsp_fault_np, rsp_fault_prot, rsp_writable, rsp_user, rsp_nocache, rsp_locked;

  int tests = 0, fails = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] tb_root = 0;
  int reads = 0;
  logic [31:0] a_last = 0, a_prev = 0;
  logic pend = 0;
  logic [1:0] lat = 0;
  logic [31:0] raddr = 0;

  always #5 clk = ~clk;

  pt_walker i_pt_walker (.*);

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      pend <= 1'b1; lat <= 2'($urandom_range(0, 2)); raddr <= mem_addr;
      reads <= reads + 1; a_prev <= a_last; a_last <= mem_addr;
    end else if (pend) begin
      if (lat == 0) begin mem_rvalid <= 1'b1; mem_rdata <= rd(raddr); pend <= 1'b0; end
      else lat <= lat - 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic set_root(input logic [31:0] v);
    @(negedge clk); root_we = 1; root_wdata = v;
    @(negedge clk); root_we = 0; tb_root = v;
  endtask

  task automatic walk(input logic [31:0] va, input bit w, input bit u,
                      input bit poke, input logic [31:0] poke_val);
    logic [31:0] d, p, da, pa_e;
    bit np, pr, ew, eu;
    int nr, r0, cyc;
    da = {tb_root[31:12], va[31:22], 2'b00};
    d = rd(da);
    p = rd({d[31:12], va[21:12], 2'b00});
    ew = d[1] & p[1]; eu = d[2] & p[2];
    np = !d[0] || !p[0]; nr = d[0] ? 2 : 1;
    pr = !np && ((w && !ew) || (u && !eu));
    pa_e = {p[31:12], va[11:0]};
    @(negedge clk);
    r0 = reads;
    req_valid = 1; req_vaddr = va; req_write = w; req_user = u;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin root_we = 1; root_wdata = poke_val; @(negedge clk); root_we = 0; end
    cyc = 0;
    while (!rsp_valid && cyc < 60) begin @(negedge clk); cyc++; end
    check(rsp_valid, "R9 response arrives", {31'b0, rsp_valid}, 32'h1);
    check(rsp_vaddr == va, "R7 vaddr", rsp_vaddr, va);
    check(rsp_fault_np == np, "R5 not-present", {31'b0, rsp_fault_np}, {31'b0, np});
    check(rsp_fault_prot == pr, "R6 protection", {31'b0, rsp_fault_prot}, {31'b0, pr});
    check(reads - r0 == nr, "R2 read count", reads - r0, nr);
    if (nr == 2) check(a_prev == da, "R2 dir addr", a_prev, da);
    else check(a_last == da, "R2 dir addr", a_last, da);
    if (nr == 2) check(a_last == {d[31:12], va[21:12], 2'b00}, "R2 pte addr", a_last, {d[31:12], va[21:12], 2'b00});
    if (!np && !pr) begin
      check(rsp_paddr == pa_e, "R3 paddr", rsp_paddr, pa_e);
      check({rsp_writable, rsp_user, rsp_nocache, rsp_locked} == {ew, eu, p[3], p[4]},
            "R4 attributes", {28'b0, rsp_writable, rsp_user, rsp_nocache, rsp_locked},
            {28'b0, ew, eu, p[3], p[4]});
    end
    @(negedge clk);
    check(!rsp_valid && req_ready, "R9 one-cycle response", {30'b0, rsp_valid, req_ready}, 32'h1);
  endtask

  task automatic build(input logic [31:0] va, input logic [31:0] dfl, input logic [31:0] pfl);
    logic [31:0] pt_base;
    pt_base = {dfl[31:12], 12'h0};
    mem[{tb_root[31:12], va[31:22], 2'b00}] = dfl;
    mem[{pt_base[31:12], va[21:12], 2'b00}] = pfl;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req, "R1 reset state",
          {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);

    set_root(32'h0010_0000);
    build(32'h0040_1ABC, 32'h0020_0007, 32'h1234_501F);
    walk(32'h0040_1ABC, 1, 1, 0, 0);
    build(32'h0080_2000, 32'h0030_0006, 32'h0);
    walk(32'h0080_2000, 0, 0, 0, 0);
    build(32'h00C0_3004, 32'h0050_0007, 32'h0000_0000);
    walk(32'h00C0_3004, 0, 0, 0, 0);
    build(32'h0100_4008, 32'h0060_0005, 32'h0AAA_A007);
    walk(32'h0100_4008, 1, 0, 0, 0);
    walk(32'h0100_4008, 0, 1, 0, 0);
    build(32'h0140_5010, 32'h0070_0003, 32'h0BBB_B007);
    walk(32'h0140_5010, 0, 1, 0, 0);
    build(32'h0180_6FFC, 32'h0090_0007, 32'h0CCC_C009);
    walk(32'h0180_6FFC, 1, 0, 0, 0);

    build(32'h01C0_7123, 32'h00A0_0007, 32'h0DDD_D017);
    walk(32'h01C0_7123, 0, 0, 1, 32'h0F00_0000);
    walk(32'h01C0_7123, 1, 1, 0, 0);

    @(negedge clk);
    root_we = 1; root_wdata = 32'h0200_0000;
    req_valid = 1; req_vaddr = 32'h01C0_7123; req_write = 0; req_user = 0;
    @(negedge clk);
    root_we = 0; req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    check(rsp_paddr == 32'h0DDD_D123 && !rsp_fault_np, "R8 same-cycle root uses old",
          rsp_paddr, 32'h0DDD_D123);
    tb_root = 32'h0200_0000;
    walk(32'h01C0_7123, 0, 0, 0, 0);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] va, dfl, pfl;
      if (i % 20 == 0) set_root({$urandom() & 32'hFFFF_F000});
      va  = $urandom();
      dfl = {$urandom() & 32'hFFFF_F000} | ($urandom_range(0, 7) != 0 ? 32'h1 : 32'h0)
            | {$urandom() & 32'h1E};
      pfl = {$urandom() & 32'hFFFF_F000} | ($urandom_range(0, 7) != 0 ? 32'h1 : 32'h0)
            | {$urandom() & 32'h1E};
      build(va, dfl, pfl);
      walk(va, 1'($urandom()), 1'($urandom()), 1'($urandom_range(0, 9) == 0), $urandom());
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule